// File: doc/BRIEF.md
# Two-Way Byte Read Cache

This block is a small read-only cache in front of a 16-byte, byte-addressed backing store. It holds two sets of two ways, and each line stores a 2-byte block. A requester presents a 4-bit byte address with `req_valid` while `rsp_ready` is high. On a hit, the addressed byte comes back one clock later with `rsp_hit` set. On a miss, the cache drops `rsp_ready`, raises `mem_rd_en` with the block address and waits a fixed `MEM_LAT` cycles. It then captures the whole block, writes it into a way of the addressed set and returns the requested byte with `rsp_hit` clear.

The replacement choice works per set. An empty way is filled first, way 0 before way 1. When both ways are valid, a one-bit LRU pointer names the victim, and that pointer always moves to the way not touched by the latest hit or fill. Two running counters of accepted hits and misses let a test compare an access trace against expected results.

Top module: `byte_read_cache`

## Requirements
- R1: An address splits into tag = addr[3:2], set = addr[1] and offset = addr[0]. Offset 0 selects bits [7:0] of a block and offset 1 selects bits [15:8], both from `mem_rd_data` and from stored lines.
- R2: After a synchronous active-low reset, `rsp_ready` is high, `rsp_valid` is low, both counters read zero and every line is invalid, so the first access to any address misses.
- R3: A request accepted while it matches a valid line in its set gives `rsp_valid`=1, `rsp_hit`=1 and the stored byte in the cycle after acceptance, and `hit_count` rises by one at that same edge.
- R4: A request accepted while it matches no valid line raises `miss_count` by one at the acceptance edge. It then holds `rsp_ready` low and `mem_rd_en` high with `mem_blk_addr` = addr[3:1] for exactly `MEM_LAT` cycles. After that it gives `rsp_valid`=1, `rsp_hit`=0 and the byte taken from `mem_rd_data`.
- R5: A miss installs both bytes of the block, so a later access to the other byte of the same block hits.
- R6: Two blocks whose tags differ but whose set is the same can be held at the same time, one in each way.
- R7: A fill uses the first invalid way of the set (way 0 before way 1). When both ways are valid, it replaces the way named by the set's LRU bit. Every hit or fill points that bit at the other way.
- R8: `req_valid` has no effect while `rsp_ready` is low. The pending fill completes with its own byte and neither counter moves during the fill.
- R9: From reset, the load trace 0xC, 0xD, 0x4, 0xC gives miss, hit, miss, hit.
- R10: `mem_blk_addr` stays constant for the whole of a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Byte address of the load |
| rsp_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle pulse carrying a result |
| rsp_hit | output | 1 | Result came from a stored line |
| rsp_data | output | DATA_W | Returned byte |
| mem_rd_en | output | 1 | Backing-store read in progress |
| mem_blk_addr | output | ADDR_W-OFF_W | Block address being fetched |
| mem_rd_data | input | DATA_W<<OFF_W | Block contents, sampled at the end of the latency window |
| hit_count | output | CNT_W | Accepted hits since reset |
| miss_count | output | CNT_W | Accepted misses since reset |

## Verification
The checker watches every cycle for the following:
- the fill window lasts exactly `MEM_LAT` cycles;
- the block address holds steady during that window;
- no result appears while the cache is not ready;
- every fill ends with a miss response;
- each counter steps by one only at the matching event.

Which way gets evicted, whether both bytes of a block were installed, and whether the returned byte is correct cannot be seen from port timing alone. The bench's trace, with expected results computed from the address split and the LRU rule, covers these. It also drives a competing request during a fill to show that the request is ignored.

// File: rtl/brc_pkg.sv
// Shared definitions for the two-way byte read cache.
// Assumes the cache is two-way; the way index is therefore one bit.
package brc_pkg;
    localparam int unsigned NUM_WAYS = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/brc_line_store.sv
// Holds valid bits, tags, block data and one LRU bit per set.
// Assumes at most one fill write and one LRU update per cycle; reads are combinational.
module brc_line_store
    import brc_pkg::*;
#(
    parameter int unsigned IDX_W  = 1,
    parameter int unsigned TAG_W  = 2,
    parameter int unsigned LINE_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [IDX_W-1:0]                     rd_idx,
    output logic [NUM_WAYS-1:0]                  rd_valid,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [NUM_WAYS-1:0][LINE_W-1:0]      rd_line,
    output logic                                 rd_lru,
    input  logic                                 wr_en,
    input  logic [IDX_W-1:0]                     wr_idx,
    input  logic                                 wr_way,
    input  logic [TAG_W-1:0]                     wr_tag,
    input  logic [LINE_W-1:0]                    wr_line,
    input  logic                                 touch_en,
    input  logic [IDX_W-1:0]                     touch_idx,
    input  logic                                 touch_way
);
    localparam int unsigned SETS = 1 << IDX_W;

    logic [SETS-1:0][NUM_WAYS-1:0]              valid_q;
    logic [SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]   tag_q;
    logic [SETS-1:0][NUM_WAYS-1:0][LINE_W-1:0]  data_q;
    logic [SETS-1:0]                            lru_q;

    // Valid bits: cleared by reset, set when a fill lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    // Tag and data arrays: written on fill, no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way]  <= wr_tag;
            data_q[wr_idx][wr_way] <= wr_line;
        end
    end

    // LRU pointer: after a use, point at the other way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_idx] <= ~touch_way;
        end
    end

    // Read port for the selected set.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_line  = data_q[rd_idx];
        rd_lru   = lru_q[rd_idx];
    end
endmodule

// File: rtl/brc_tag_match.sv
// Compares the lookup tag against both ways of one set, selects the byte of a
// matching line by offset, and picks the victim way for a fill.
// Assumes at most one way matches (fills only occur on a miss).
module brc_tag_match
    import brc_pkg::*;
#(
    parameter int unsigned TAG_W  = 2,
    parameter int unsigned OFF_W  = 1,
    parameter int unsigned DATA_W = 8
) (
    input  logic [NUM_WAYS-1:0]                          rd_valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0]               rd_tag,
    input  logic [NUM_WAYS-1:0][(DATA_W<<OFF_W)-1:0]     rd_line,
    input  logic                                         rd_lru,
    input  logic [TAG_W-1:0]                             look_tag,
    input  logic [OFF_W-1:0]                             look_off,
    output logic                                         hit,
    output logic                                         hit_way,
    output logic [DATA_W-1:0]                            hit_byte,
    output logic                                         victim_way
);
    localparam int unsigned LINE_W = DATA_W << OFF_W;

    logic [NUM_WAYS-1:0] way_match;
    logic [LINE_W-1:0]   sel_line;

    // One comparator per way.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign way_match[w] = rd_valid[w] && (rd_tag[w] == look_tag);
    end

    // Encode the matching way and pick the byte out of its line.
    always_comb begin
        hit     = |way_match;
        hit_way = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (way_match[w]) hit_way = w[0];
        end
        sel_line = rd_line[hit_way];
        hit_byte = sel_line[look_off*DATA_W +: DATA_W];
    end

    // Victim: first empty way, otherwise the way the LRU bit names.
    always_comb begin
        if (!rd_valid[0])      victim_way = 1'b0;
        else if (!rd_valid[1]) victim_way = 1'b1;
        else                   victim_way = rd_lru;
    end
endmodule

// File: rtl/brc_fill_ctrl.sv
// Sequences a single outstanding miss: waits MEM_LAT cycles on the backing
// store and flags the cycle in which the returned block must be captured.
// Assumes the backing store delivers valid data after MEM_LAT cycles (MEM_LAT >= 1).
module brc_fill_ctrl
    import brc_pkg::*;
#(
    parameter int unsigned MEM_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fill_done
);
    localparam int unsigned LAT_W = $clog2(MEM_LAT + 1);

    fill_state_e      state_q;
    logic [LAT_W-1:0] wait_q;

    // Idle/fill state and latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_FILL;
                    wait_q  <= '0;
                end
                ST_FILL: begin
                    wait_q <= wait_q + 1'b1;
                    if (fill_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Busy for the whole window; done on its last cycle.
    always_comb begin
        busy      = (state_q == ST_FILL);
        fill_done = busy && (wait_q == LAT_W'(MEM_LAT - 1));
    end
endmodule

// File: rtl/byte_read_cache.sv
// Two-set, two-way read-only byte cache with 2-byte blocks in front of a
// fixed-latency backing store. One miss at a time; requests are only taken
// while rsp_ready is high. Results are registered and pulse rsp_valid.
module byte_read_cache
    import brc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned IDX_W   = 1,
    parameter int unsigned OFF_W   = 1,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned MEM_LAT = 4,
    parameter int unsigned CNT_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        rsp_ready,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        mem_rd_en,
    output logic [ADDR_W-OFF_W-1:0]     mem_blk_addr,
    input  logic [(DATA_W<<OFF_W)-1:0]  mem_rd_data,
    output logic [CNT_W-1:0]            hit_count,
    output logic [CNT_W-1:0]            miss_count
);
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned LINE_W = DATA_W << OFF_W;

    logic                                 busy, fill_done, start_miss, accept_hit;
    logic [ADDR_W-1:0]                    pend_q, cur_addr;
    logic [TAG_W-1:0]                     cur_tag;
    logic [IDX_W-1:0]                     cur_idx;
    logic [OFF_W-1:0]                     cur_off;
    logic [NUM_WAYS-1:0]                  rd_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0]       rd_tag;
    logic [NUM_WAYS-1:0][LINE_W-1:0]      rd_line;
    logic                                 rd_lru, hit, hit_way, victim_way;
    logic [DATA_W-1:0]                    hit_byte, fill_byte;

    // Address in use: the pending miss while filling, else the new request.
    always_comb begin
        cur_addr   = busy ? pend_q : req_addr;
        cur_off    = cur_addr[OFF_W-1:0];
        cur_idx    = cur_addr[OFF_W +: IDX_W];
        cur_tag    = cur_addr[ADDR_W-1 -: TAG_W];
        accept_hit = !busy && req_valid && hit;
        start_miss = !busy && req_valid && !hit;
        fill_byte  = mem_rd_data[cur_off*DATA_W +: DATA_W];
    end

    brc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (cur_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line),
        .rd_lru    (rd_lru),
        .wr_en     (fill_done),
        .wr_idx    (cur_idx),
        .wr_way    (victim_way),
        .wr_tag    (cur_tag),
        .wr_line   (mem_rd_data),
        .touch_en  (accept_hit || fill_done),
        .touch_idx (cur_idx),
        .touch_way (fill_done ? victim_way : hit_way)
    );

    brc_tag_match #(.TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_match (
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_line    (rd_line),
        .rd_lru     (rd_lru),
        .look_tag   (cur_tag),
        .look_off   (cur_off),
        .hit        (hit),
        .hit_way    (hit_way),
        .hit_byte   (hit_byte),
        .victim_way (victim_way)
    );

    brc_fill_ctrl #(.MEM_LAT(MEM_LAT)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_miss),
        .busy      (busy),
        .fill_done (fill_done)
    );

    // Capture the missing address for the duration of the fill.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= '0;
        else if (start_miss) pend_q <= req_addr;
    end

    // Registered response and hit/miss counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_data   <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            rsp_valid <= accept_hit || fill_done;
            if (accept_hit) begin
                rsp_hit   <= 1'b1;
                rsp_data  <= hit_byte;
                hit_count <= hit_count + 1'b1;
            end else if (fill_done) begin
                rsp_hit  <= 1'b0;
                rsp_data <= fill_byte;
            end
            if (start_miss) miss_count <= miss_count + 1'b1;
        end
    end

    // Port-level handshake and backing-store request.
    always_comb begin
        rsp_ready    = !busy;
        mem_rd_en    = busy;
        mem_blk_addr = pend_q[ADDR_W-1:OFF_W];
    end
endmodule

// File: rtl/brc_checker.sv
// Port-level temporal checks for byte_read_cache, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled during it.
module brc_checker #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned OFF_W   = 1,
    parameter int unsigned MEM_LAT = 4,
    parameter int unsigned CNT_W   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rsp_ready,
    input logic                    rsp_valid,
    input logic                    rsp_hit,
    input logic                    mem_rd_en,
    input logic [ADDR_W-OFF_W-1:0] mem_blk_addr,
    input logic [CNT_W-1:0]        hit_count,
    input logic [CNT_W-1:0]        miss_count
);
    logic [15:0] fill_len_q;

    // Length of the current backing-store window.
    always_ff @(posedge clk) begin
        if (!rst_n)         fill_len_q <= '0;
        else if (mem_rd_en) fill_len_q <= fill_len_q + 1'b1;
        else                fill_len_q <= '0;
    end

    // R4
    fill_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_en) |-> fill_len_q == 16'(MEM_LAT));

    // R4
    fill_ends_in_miss_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_en) |-> (rsp_valid && !rsp_hit));

    // R4
    miss_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |-> miss_count == $past(miss_count) + 1'b1);

    // R3
    hit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> hit_count == $past(hit_count) + 1'b1);

    // R8
    no_rsp_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> !rsp_valid);

    // R8
    counters_frozen_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> ($stable(hit_count) && $stable(miss_count)));

    // R10
    blk_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> $stable(mem_blk_addr));
endmodule

bind byte_read_cache brc_checker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MEM_LAT(MEM_LAT), .CNT_W(CNT_W)
) u_brc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rsp_ready    (rsp_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .mem_rd_en    (mem_rd_en),
    .mem_blk_addr (mem_blk_addr),
    .hit_count    (hit_count),
    .miss_count   (miss_count)
);

// File: tb/tb_byte_read_cache.sv
// Self-checking bench: a trace table walked by one loop, then directed tests.
module tb_byte_read_cache;
    localparam int unsigned MEM_LAT = 4;
    localparam int          NVEC    = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_addr = '0;
    logic        rsp_ready, rsp_valid, rsp_hit, mem_rd_en;
    logic [7:0]  rsp_data;
    logic [2:0]  mem_blk_addr;
    logic [15:0] mem_rd_data;
    logic [15:0] hit_count, miss_count;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Backing-store contents: byte at address a is 0xA0 + a.
    function automatic logic [7:0] mem_byte(input logic [3:0] a);
        return 8'hA0 + {4'h0, a};
    endfunction

    // R1: offset 0 in bits [7:0], offset 1 in bits [15:8].
    assign mem_rd_data = {mem_byte({mem_blk_addr, 1'b1}), mem_byte({mem_blk_addr, 1'b0})};

    byte_read_cache #(.MEM_LAT(MEM_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .mem_rd_en(mem_rd_en), .mem_blk_addr(mem_blk_addr),
        .mem_rd_data(mem_rd_data), .hit_count(hit_count), .miss_count(miss_count)
    );

    // Trace vectors {expected hit, address}; expected data comes from mem_byte.
    localparam logic [4:0] VEC [NVEC] = '{
        {1'b0, 4'hC}, {1'b1, 4'hD}, {1'b0, 4'h4}, {1'b1, 4'hC},
        {1'b1, 4'h5}, {1'b0, 4'h0}, {1'b0, 4'hC}, {1'b1, 4'h1},
        {1'b0, 4'h4}, {1'b1, 4'h5}, {1'b1, 4'h0}, {1'b0, 4'h2},
        {1'b1, 4'h3}, {1'b0, 4'hE}, {1'b1, 4'h2}, {1'b1, 4'hF},
        {1'b0, 4'hA}, {1'b0, 4'h3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One load; returns data, hit flag, negedges until result, and fill-window sanity.
    task automatic do_load(input logic [3:0] a, input bit side_req, input logic [3:0] side_a,
                           output logic [7:0] d, output logic h, output int cyc,
                           output bit win_ok);
        @(negedge clk);
        while (!rsp_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = side_req;
        req_addr  = side_a;
        cyc = 1;
        win_ok = 1'b1;
        while (!rsp_valid && cyc < 100) begin
            if (rsp_ready || !mem_rd_en || mem_blk_addr != a[3:1]) win_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        d = rsp_data;
        h = rsp_hit;
    endtask

    initial begin
        logic [7:0] d;
        logic       h;
        int         cyc, exp_hits, exp_miss;
        bit         win_ok;
        logic [15:0] h_before;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(rsp_ready === 1'b1, "R2 ready after reset", int'(rsp_ready), 1);
        check(rsp_valid === 1'b0, "R2 no result after reset", int'(rsp_valid), 0);
        check(hit_count == 0 && miss_count == 0, "R2 counters zero",
              int'(hit_count + miss_count), 0);

        // Trace: R9 opens it; R5/R6/R7 via neighbours, shared sets and evictions.
        exp_hits = 0;
        exp_miss = 0;
        for (int i = 0; i < NVEC; i++) begin
            do_load(VEC[i][3:0], 1'b0, 4'h0, d, h, cyc, win_ok);
            if (VEC[i][4]) exp_hits++; else exp_miss++;
            check(h === VEC[i][4], (i < 4) ? "R9 trace hit flag" : "R7 hit flag",
                  int'(h), int'(VEC[i][4]));
            check(d === mem_byte(VEC[i][3:0]), "R1 returned byte", int'(d),
                  int'(mem_byte(VEC[i][3:0])));
            if (VEC[i][4])
                check(cyc == 1, "R3 hit latency", cyc, 1);
            else begin
                check(cyc == MEM_LAT + 1, "R4 miss latency", cyc, MEM_LAT + 1);
                check(win_ok, "R10 fill window ready low and block addr held", 0, 1);
            end
        end
        check(hit_count == 16'(exp_hits), "R3 hit count", int'(hit_count), exp_hits);
        check(miss_count == 16'(exp_miss), "R4 miss count", int'(miss_count), exp_miss);

        // R8: a request for a resident byte during a fill is ignored.
        h_before = hit_count;
        do_load(4'h9, 1'b1, 4'h0, d, h, cyc, win_ok);
        check(h === 1'b0 && d === mem_byte(4'h9), "R8 fill result kept", int'(d),
              int'(mem_byte(4'h9)));
        check(hit_count == h_before, "R8 no hit counted in fill", int'(hit_count),
              int'(h_before));
        check(miss_count == 16'(exp_miss + 1), "R8 miss count", int'(miss_count), exp_miss + 1);
        // R5: neighbour of the fresh block hits.
        do_load(4'h8, 1'b0, 4'h0, d, h, cyc, win_ok);
        check(h === 1'b1 && d === mem_byte(4'h8), "R5 neighbour byte hits", int'(d),
              int'(mem_byte(4'h8)));
        // R7: 0x9 displaced the LRU way (block 4/5), not the recent 0x0.
        do_load(4'h0, 1'b0, 4'h0, d, h, cyc, win_ok);
        check(h === 1'b1, "R7 recently used block kept", int'(h), 1);
        do_load(4'h5, 1'b0, 4'h0, d, h, cyc, win_ok);
        check(h === 1'b0, "R7 LRU block evicted", int'(h), 0);

        // R2: reset during operation clears lines and counters.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(hit_count == 0 && miss_count == 0, "R2 counters cleared by reset",
              int'(hit_count + miss_count), 0);
        do_load(4'h0, 1'b0, 4'h0, d, h, cyc, win_ok);
        check(h === 1'b0, "R2 lines invalid after reset", int'(h), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule